// File: doc/BRIEF.md
# Calibrated Seconds Counter

This block turns a slow crystal clock of roughly 33.33 kHz into a once-per-second strobe and keeps a 32-bit count of elapsed seconds. A programmable tick limit sets the nominal length of a second. A 4-bit fractional trim adds one extra tick to some seconds in each 16-second cycle, which corrects long-term drift below the resolution of one tick.

Software programs the period through a calibration word. Every calibration write restarts the current second, so the following strobe lands exactly one full period after the write. A new time written through the set-time port does not appear at once. It is held, can be read back, and is loaded into the seconds count at the next second boundary. A flag then reports that the load has happened, which tells a reader whether the count or the held value is the current time.

Top module: `rtc_seconds_core`

## Requirements
- R1: Synchronous active-high reset clears `secs`, `tick`, `sec_pulse`, `time_loaded` and `set_rdback` to zero. It also loads the calibration word 0x198233, which gives tick limit 0x8233, fraction 9 and trim enabled.
- R2: The calibration word is 21 bits. Bits [15:0] are the tick limit, bits [19:16] are the fraction value, and bit 20 enables the fractional trim.
- R3: The tick counter runs from 0 up to the second's limit inclusive and then returns to 0. A second therefore lasts limit+1 clock cycles, and `tick` shows the low 16 bits of the counter.
- R4: A 4-bit phase counter starts at 0 and advances by one at each second boundary, wrapping from 15 to 0. When the trim is enabled and the phase of the current second is below the fraction value, that second's limit is one larger.
- R5: A calibration write sets `tick` to 0 on the next cycle and leaves the phase counter unchanged. The next `sec_pulse` comes exactly limit+1 cycles after the write. A write that falls on a boundary cycle suppresses that boundary.
- R6: `sec_pulse` is high for the one cycle in which `tick` has just returned to 0 at a boundary, and `secs` takes its new value in that same cycle.
- R7: A set-time write shows its value on `set_rdback` on the next cycle and clears `time_loaded`. It leaves `secs` unchanged until the next boundary.
- R8: At the first boundary after a set-time write, `secs` takes the written value and `time_loaded` goes high. `set_rdback` keeps its value.
- R9: At every other boundary `secs` increases by one, wrapping from 0xFFFFFFFF to 0, and `secs` does not change between boundaries.
- R10: A set-time write in the same cycle as a boundary takes priority over the load. That boundary increments `secs` and keeps `time_loaded` low, and the written value loads at the following boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_wr | input | 1 | Calibration write strobe |
| cal_data | input | 21 | Calibration word: trim enable, fraction, tick limit |
| set_wr | input | 1 | Set-time write strobe |
| set_data | input | 32 | Time value to load at the next boundary |
| secs | output | 32 | Current seconds count |
| tick | output | 16 | Current tick count within the second |
| sec_pulse | output | 1 | One-cycle strobe at each second boundary |
| set_rdback | output | 32 | Last written set-time value |
| time_loaded | output | 1 | High once the written time has been taken in |

## Verification
The period is measured edge by edge over a table of calibration words. The table holds one word with the trim off but a non-zero fraction, one with the trim on and fraction 0, and others with fractions 5 and 15 over a full 16-second phase cycle. Together these separate a wrong enable decode from a wrong comparison against the phase and from an off-by-one in the inclusive tick limit. The default word is timed once after reset to confirm both the reset value and the trimmed first second. Directed cases cover a calibration write in mid-second, a time write in mid-second, a time write on the boundary cycle, and the wrap of the seconds count.

// File: rtl/rtc_sec_pkg.sv
package rtc_sec_pkg;
  localparam int TICK_W_DEF = 16;
  localparam int FRAC_W_DEF = 4;
  localparam int SEC_W_DEF  = 32;
  localparam logic [20:0] CAL_RESET_DEF = 21'h198233;

  // progress of a written time value
  typedef enum logic [1:0] {
    SET_IDLE    = 2'd0,
    SET_PENDING = 2'd1,
    SET_TAKEN   = 2'd2
  } set_state_e;
endpackage

// File: rtl/rtc_cal_reg.sv
module rtc_cal_reg #(
  parameter int              CAL_W     = 21,
  parameter logic [CAL_W-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CAL_W-1:0] wdata,
  output logic [CAL_W-1:0] cal
);
  always_ff @(posedge clk) begin
    if (rst)     cal <= RESET_VAL;
    else if (wr) cal <= wdata;
  end
endmodule

// File: rtl/rtc_tick_div.sv
module rtc_tick_div #(
  parameter int TICK_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic [TICK_W:0] limit,
  output logic [TICK_W-1:0] tick,
  output logic            wrap
);
  logic [TICK_W:0] cnt;

  // a calibration write overrides the boundary
  assign wrap = !clear && (cnt == limit);
  assign tick = cnt[TICK_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)                cnt <= '0;
    else if (clear || wrap) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rtc_frac_phase.sv
module rtc_frac_phase #(
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [FRAC_W-1:0] phase
);
  always_ff @(posedge clk) begin
    if (rst)      phase <= '0;
    else if (adv) phase <= phase + 1'b1;
  end
endmodule

// File: rtl/rtc_sec_count.sv
module rtc_sec_count
  import rtc_sec_pkg::*;
#(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrap,
  input  logic             set_wr,
  input  logic [SEC_W-1:0] set_data,
  output logic [SEC_W-1:0] secs,
  output logic [SEC_W-1:0] set_hold,
  output logic             loaded,
  output logic             pulse
);
  set_state_e st;

  function automatic logic [SEC_W-1:0] next_secs(input logic [SEC_W-1:0] s);
    return s + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      secs     <= '0;
      set_hold <= '0;
      st       <= SET_IDLE;
      pulse    <= 1'b0;
    end else begin
      pulse <= wrap;
      if (set_wr) begin
        set_hold <= set_data;
        st       <= SET_PENDING;
      end
      if (wrap) begin
        if (st == SET_PENDING && !set_wr) begin
          secs <= set_hold;
          st   <= SET_TAKEN;
        end else begin
          secs <= next_secs(secs);
        end
      end
    end
  end

  assign loaded = (st == SET_TAKEN);
endmodule

// File: rtl/rtc_seconds_core.sv
module rtc_seconds_core
  import rtc_sec_pkg::*;
#(
  parameter int TICK_W = TICK_W_DEF,
  parameter int FRAC_W = FRAC_W_DEF,
  parameter int SEC_W  = SEC_W_DEF,
  localparam int CAL_W = TICK_W + FRAC_W + 1,
  parameter logic [CAL_W-1:0] CAL_RESET = CAL_W'(CAL_RESET_DEF)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_wr,
  input  logic [CAL_W-1:0] cal_data,
  input  logic             set_wr,
  input  logic [SEC_W-1:0] set_data,
  output logic [SEC_W-1:0] secs,
  output logic [TICK_W-1:0] tick,
  output logic             sec_pulse,
  output logic [SEC_W-1:0] set_rdback,
  output logic             time_loaded
);
  localparam int EN_BIT = CAL_W - 1;

  logic [CAL_W-1:0]  cal_q;
  logic [FRAC_W-1:0] phase;
  logic [TICK_W:0]   limit;
  logic              wrap;

  // limit of the current second: base ticks plus one trim tick
  function automatic logic [TICK_W:0] second_limit(
    input logic [CAL_W-1:0]  c,
    input logic [FRAC_W-1:0] ph
  );
    logic [TICK_W:0] base;
    logic            extra;
    base  = {1'b0, c[TICK_W-1:0]};
    extra = c[EN_BIT] && (ph < c[TICK_W +: FRAC_W]);
    return base + {{TICK_W{1'b0}}, extra};
  endfunction

  assign limit = second_limit(cal_q, phase);

  rtc_cal_reg #(.CAL_W(CAL_W), .RESET_VAL(CAL_RESET)) cal_i (
    .clk(clk), .rst(rst), .wr(cal_wr), .wdata(cal_data), .cal(cal_q)
  );

  rtc_tick_div #(.TICK_W(TICK_W)) div_i (
    .clk(clk), .rst(rst), .clear(cal_wr), .limit(limit),
    .tick(tick), .wrap(wrap)
  );

  rtc_frac_phase #(.FRAC_W(FRAC_W)) ph_i (
    .clk(clk), .rst(rst), .adv(wrap), .phase(phase)
  );

  rtc_sec_count #(.SEC_W(SEC_W)) cnt_i (
    .clk(clk), .rst(rst), .wrap(wrap), .set_wr(set_wr), .set_data(set_data),
    .secs(secs), .set_hold(set_rdback), .loaded(time_loaded), .pulse(sec_pulse)
  );
endmodule

// File: rtl/rtc_seconds_core_chk.sv
module rtc_seconds_core_chk #(
  parameter int TICK_W = 16,
  parameter int SEC_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cal_wr,
  input logic              set_wr,
  input logic [SEC_W-1:0]  set_data,
  input logic [TICK_W-1:0] tick,
  input logic [TICK_W:0]   limit,
  input logic              sec_pulse,
  input logic [SEC_W-1:0]  secs,
  input logic [SEC_W-1:0]  set_rdback,
  input logic              time_loaded
);
  a_r5_cal_restart: assert property (@(posedge clk) disable iff (rst)
    cal_wr |=> (tick == '0) && !sec_pulse);

  a_r3_tick_bound: assert property (@(posedge clk) disable iff (rst)
    {1'b0, tick} <= limit);

  a_r6_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
    sec_pulse |-> (tick == '0));

  a_r7_write_held: assert property (@(posedge clk) disable iff (rst)
    set_wr |=> !time_loaded && (set_rdback == $past(set_data)));

  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    $rose(time_loaded) |-> sec_pulse && (secs == $past(set_rdback)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !sec_pulse |-> $stable(secs));

  a_r9_count: assert property (@(posedge clk) disable iff (rst)
    (sec_pulse && !$rose(time_loaded)) |-> (secs == $past(secs) + 1'b1));
endmodule

bind rtc_seconds_core rtc_seconds_core_chk #(.TICK_W(TICK_W), .SEC_W(SEC_W)) chk_i (
  .clk(clk), .rst(rst), .cal_wr(cal_wr), .set_wr(set_wr), .set_data(set_data),
  .tick(tick), .limit(limit), .sec_pulse(sec_pulse), .secs(secs),
  .set_rdback(set_rdback), .time_loaded(time_loaded)
);

// File: tb/rtc_seconds_core_tb_top.sv
module rtc_seconds_core_tb_top;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [20:0] cal;
    logic [7:0]  nsec;
  } vec_t;

  // calibration words (R2 layout) and how many seconds to time each
  localparam vec_t VECS [5] = '{
    '{21'h000003, 8'd4},    // trim off, plain 4-cycle second
    '{21'h150004, 8'd16},   // trim on, fraction 5
    '{21'h0F0002, 8'd3},    // fraction 15 but trim off
    '{21'h1F0001, 8'd16},   // trim on, fraction 15
    '{21'h100005, 8'd3}     // trim on, fraction 0
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cal_wr = 1'b0;
  logic [20:0] cal_data = '0;
  logic        set_wr = 1'b0;
  logic [31:0] set_data = '0;
  logic [31:0] secs;
  logic [15:0] tick;
  logic        sec_pulse;
  logic [31:0] set_rdback;
  logic        time_loaded;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [3:0]  ph = '0;
  logic [31:0] exp_secs = '0;
  logic [20:0] cur_cal = 21'h198233;

  always #(CLK_P/2) clk = ~clk;

  rtc_seconds_core dut_i (
    .clk(clk), .rst(rst), .cal_wr(cal_wr), .cal_data(cal_data),
    .set_wr(set_wr), .set_data(set_data), .secs(secs), .tick(tick),
    .sec_pulse(sec_pulse), .set_rdback(set_rdback), .time_loaded(time_loaded)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // cycles in one second per R3/R4
  function automatic int exp_len(input logic [20:0] c, input logic [3:0] p);
    int len;
    len = int'(c[15:0]) + 1;
    if (c[20] && (p < c[19:16])) len = len + 1;
    return len;
  endfunction

  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!sec_pulse && n < 70000);
  endtask

  task automatic cal_write(input logic [20:0] w);
    cal_data = w;
    cal_wr   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cal_wr   = 1'b0;
    cur_cal  = w;
  endtask

  task automatic set_write(input logic [31:0] v);
    set_data = v;
    set_wr   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    set_wr   = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 secs", secs, 0);
    chk("R1 tick", tick, 0);
    chk("R1 sec_pulse", sec_pulse, 0);
    chk("R1 time_loaded", time_loaded, 0);
    chk("R1 set_rdback", set_rdback, 0);

    // R1 default word: limit 0x8233, phase 0 < fraction 9 adds a tick
    measure(n);
    chk("R1 default period", n, exp_len(21'h198233, ph));
    ph++; exp_secs++;
    chk("R9 secs after first second", secs, exp_secs);

    // R2 R3 R4 table of calibration words
    foreach (VECS[i]) begin
      cal_write(VECS[i].cal);
      chk("R5 tick cleared by write", tick, 0);
      for (int s = 0; s < int'(VECS[i].nsec); s++) begin
        measure(n);
        chk("R4 second length", n, exp_len(VECS[i].cal, ph));
        ph++; exp_secs++;
        chk("R9 secs increment", secs, exp_secs);
        chk("R6 tick zero at pulse", tick, 0);
      end
    end

    // R5 calibration write in mid-second restarts the period
    cal_write(21'h000003);
    measure(n); ph++; exp_secs++;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    chk("R3 tick mid second", tick, 2);
    cal_write(21'h000003);
    chk("R5 tick after mid write", tick, 0);
    measure(n);
    chk("R5 full period after write", n, 4);
    ph++; exp_secs++;
    chk("R5 secs after restart", secs, exp_secs);

    // R7 R8 set-time in mid-second
    @(posedge clk); @(negedge clk);
    set_write(32'h1234_5678);
    chk("R7 readback", set_rdback, 32'h1234_5678);
    chk("R7 secs unchanged", secs, exp_secs);
    chk("R7 loaded low", time_loaded, 0);
    measure(n);
    chk("R3 remaining cycles", n, 2);
    chk("R8 secs loaded", secs, 32'h1234_5678);
    chk("R8 loaded high", time_loaded, 1);
    chk("R8 readback kept", set_rdback, 32'h1234_5678);
    measure(n);
    chk("R9 increment after load", secs, 32'h1234_5679);

    // R10 set-time on the boundary cycle (tick 3 of a 4-cycle second)
    repeat (3) begin @(posedge clk); @(negedge clk); end
    set_write(32'hFFFF_FFFF);
    chk("R10 pulse on write cycle", sec_pulse, 1);
    chk("R10 secs incremented", secs, 32'h1234_567A);
    chk("R10 loaded stays low", time_loaded, 0);
    measure(n);
    chk("R10 period", n, 4);
    chk("R10 load at following boundary", secs, 32'hFFFF_FFFF);
    chk("R8 loaded after deferred write", time_loaded, 1);
    measure(n);
    chk("R9 wrap to zero", secs, 0);
    @(posedge clk); @(negedge clk);
    chk("R6 pulse one cycle", sec_pulse, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule